// File: doc/BRIEF.md
# Subframe Chip-Count Timing Generator

This block keeps a free-running chip counter that marks out a fixed-length physical subframe of 2880 chips. The counter moves forward by one on every system clock cycle on which a chip-rate enable tick is high. From the count the block decodes a set of timing strobes. A bit strobe fires once every 8 chips and a byte strobe once every 64 chips. A frame strobe marks the start of the subframe. Early byte and early frame strobes lead their partners by one bit time (8 chips). A slot-window level runs from the early frame strobe up to the next frame strobe.

Transmit and receive use the same counter. The block has no direction input, so a change of direction cannot reset or shift the timing. One shared output pin carries either the slot window or the transmit data, and a select input chooses which. Downstream logic (the modem datapath and the interrupt logic) uses the strobes as single-chip markers. An external host can use the pin to lock its software to the frame boundary.

Top module: `subframe_timing_gen`

## Requirements
- R1: On a clock edge with `chip_tick_i` high, `chip_cnt_o` steps by one from 0 to 2879, and from 2879 it returns to 0.
- R2: On a clock edge with `chip_tick_i` low, `chip_cnt_o` and every strobe output keep their values.
- R3: `bit_stb_o` is 1 exactly when `chip_cnt_o` is a multiple of 8.
- R4: `byte_stb_o` is 1 exactly when `chip_cnt_o` is a multiple of 64.
- R5: `frame_stb_o` is 1 exactly when `chip_cnt_o` is 0.
- R6: `pre_byte_stb_o` is 1 exactly when `chip_cnt_o` plus 8 is a multiple of 64 (56, 120, ... 2808, 2872). The value 2872 leads the byte strobe at 0 across the wrap.
- R7: `pre_frame_stb_o` is 1 exactly when `chip_cnt_o` is 2872.
- R8: `slot_win_o` is 1 exactly when `chip_cnt_o` is between 2872 and 2879. It is therefore high from the early frame strobe until the frame strobe, and it falls when the count returns to 0.
- R9: `share_pin_o` equals `slot_win_o` when `pin_sel_i` is 0 and equals `tx_data_i` when `pin_sel_i` is 1. This path is combinational.
- R10: A clock edge with `rst_i` high (synchronous, active high) sets the count to 0. After that edge the bit, byte and frame strobes are 1, and the early strobes and the slot window are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| chip_tick_i | input | 1 | Chip-rate enable; the counter advances on cycles where this is high |
| pin_sel_i | input | 1 | Shared pin source: 0 selects the slot window, 1 selects transmit data |
| tx_data_i | input | 1 | Transmit data bit to route to the shared pin |
| chip_cnt_o | output | 12 | Current chip count, 0 to 2879 |
| bit_stb_o | output | 1 | Bit strobe |
| byte_stb_o | output | 1 | Byte strobe |
| frame_stb_o | output | 1 | Frame strobe |
| pre_byte_stb_o | output | 1 | Early byte strobe, 8 chips ahead of the byte strobe |
| pre_frame_stb_o | output | 1 | Early frame strobe, 8 chips ahead of the frame strobe |
| slot_win_o | output | 1 | Slot window level |
| share_pin_o | output | 1 | Shared output pin |

## Verification
The assertions assume that `chip_tick_i`, `pin_sel_i` and `tx_data_i` are known (0 or 1) on every clock edge once reset is released. They assume nothing about how often the tick comes, so bursts, long gaps and back-to-back ticks are all legal. The stimulus changes the inputs only at falling clock edges and draws each tick from a fixed-seed random source at several densities. It adds directed stretches: long runs with no tick, a reset in the middle of a frame, and enough ticks to wrap the count more than once. This lets every strobe position, including the early byte strobe at the wrap, be reached under both pin selections.

// File: rtl/sft_pkg.sv
package sft_pkg;

    // Decoded timing strobes, all aligned to one chip count
    typedef struct packed {
        logic bit_s;
        logic byte_s;
        logic frame_s;
        logic pre_byte_s;
        logic pre_frame_s;
        logic slot_s;
    } sft_strobes_t;

    localparam sft_strobes_t SFT_STROBES_IDLE = '{default: 1'b0};

endpackage

// File: rtl/sft_chip_counter.sv
module sft_chip_counter #(
    parameter int CHIPS_PER_FRAME = 2880,
    parameter int CNT_W           = $clog2(CHIPS_PER_FRAME)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CHIPS_PER_FRAME - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv_i) begin
            if (state_q.cnt == LAST_CNT) begin
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + CNT_W'(1);
            end
        end
        if (rst_i) begin
            state_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    assign cnt_q_o = state_q.cnt;
    assign cnt_d_o = state_d.cnt;

endmodule

// File: rtl/sft_strobe_decode.sv
module sft_strobe_decode
    import sft_pkg::*;
#(
    parameter int CHIPS_PER_FRAME = 2880,
    parameter int CHIPS_PER_BIT   = 8,
    parameter int BITS_PER_BYTE   = 8,
    parameter int CNT_W           = $clog2(CHIPS_PER_FRAME)
) (
    input  logic [CNT_W-1:0] cnt_i,
    output sft_strobes_t     strb_o
);

    localparam int CHIPS_PER_BYTE = CHIPS_PER_BIT * BITS_PER_BYTE;
    localparam int LEAD           = CHIPS_PER_BIT;
    localparam int WIN_START      = CHIPS_PER_FRAME - LEAD;

    int unsigned cur;
    int unsigned ahead;

    always_comb begin
        cur   = int'(cnt_i);
        // count that will be current one bit time from now, folded over the wrap
        ahead = cur + LEAD;
        if (ahead >= CHIPS_PER_FRAME) begin
            ahead = ahead - CHIPS_PER_FRAME;
        end

        strb_o             = SFT_STROBES_IDLE;
        strb_o.bit_s       = (cur % CHIPS_PER_BIT) == 0;
        strb_o.byte_s      = (cur % CHIPS_PER_BYTE) == 0;
        strb_o.frame_s     = (cur == 0);
        strb_o.pre_byte_s  = (ahead % CHIPS_PER_BYTE) == 0;
        strb_o.pre_frame_s = (ahead == 0);
        strb_o.slot_s      = (cur >= WIN_START);
    end

endmodule

// File: rtl/sft_pin_mux.sv
module sft_pin_mux #(
    parameter bit SEL_HIGH_PICKS_TX = 1'b1
) (
    input  logic sel_i,
    input  logic win_i,
    input  logic tx_i,
    output logic pin_o
);

    logic pick_tx;

    generate
        if (SEL_HIGH_PICKS_TX) begin : g_sel_high
            assign pick_tx = sel_i;
        end else begin : g_sel_low
            assign pick_tx = ~sel_i;
        end
    endgenerate

    always_comb begin
        pin_o = pick_tx ? tx_i : win_i;
    end

endmodule

// File: rtl/subframe_timing_gen.sv
module subframe_timing_gen
    import sft_pkg::*;
#(
    parameter int CHIPS_PER_FRAME = 2880,
    parameter int CHIPS_PER_BIT   = 8,
    parameter int BITS_PER_BYTE   = 8,
    parameter int CNT_W           = $clog2(CHIPS_PER_FRAME)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             chip_tick_i,
    input  logic             pin_sel_i,
    input  logic             tx_data_i,
    output logic [CNT_W-1:0] chip_cnt_o,
    output logic             bit_stb_o,
    output logic             byte_stb_o,
    output logic             frame_stb_o,
    output logic             pre_byte_stb_o,
    output logic             pre_frame_stb_o,
    output logic             slot_win_o,
    output logic             share_pin_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    sft_strobes_t     strb_next;
    sft_strobes_t     strb_d, strb_q;

    sft_chip_counter #(
        .CHIPS_PER_FRAME (CHIPS_PER_FRAME),
        .CNT_W           (CNT_W)
    ) cnt_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .adv_i   (chip_tick_i),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d)
    );

    // Decode the next count so strobes register on the same edge as the count
    sft_strobe_decode #(
        .CHIPS_PER_FRAME (CHIPS_PER_FRAME),
        .CHIPS_PER_BIT   (CHIPS_PER_BIT),
        .BITS_PER_BYTE   (BITS_PER_BYTE),
        .CNT_W           (CNT_W)
    ) dec_i (
        .cnt_i  (cnt_d),
        .strb_o (strb_next)
    );

    always_comb begin
        strb_d = strb_next;
    end

    always_ff @(posedge clk_i) begin
        strb_q <= strb_d;
    end

    sft_pin_mux #(
        .SEL_HIGH_PICKS_TX (1'b1)
    ) mux_i (
        .sel_i (pin_sel_i),
        .win_i (strb_q.slot_s),
        .tx_i  (tx_data_i),
        .pin_o (share_pin_o)
    );

    assign chip_cnt_o      = cnt_q;
    assign bit_stb_o       = strb_q.bit_s;
    assign byte_stb_o      = strb_q.byte_s;
    assign frame_stb_o     = strb_q.frame_s;
    assign pre_byte_stb_o  = strb_q.pre_byte_s;
    assign pre_frame_stb_o = strb_q.pre_frame_s;
    assign slot_win_o      = strb_q.slot_s;

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
    parameter int CHIPS_PER_FRAME = 2880,
    parameter int CHIPS_PER_BIT   = 8,
    parameter int BITS_PER_BYTE   = 8,
    parameter int CNT_W           = $clog2(CHIPS_PER_FRAME)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             chip_tick_i,
    input logic             pin_sel_i,
    input logic             tx_data_i,
    input logic [CNT_W-1:0] chip_cnt_o,
    input logic             bit_stb_o,
    input logic             byte_stb_o,
    input logic             frame_stb_o,
    input logic             pre_byte_stb_o,
    input logic             pre_frame_stb_o,
    input logic             slot_win_o,
    input logic             share_pin_o
);

    localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(CHIPS_PER_FRAME - 1);
    localparam logic [CNT_W-1:0] WIN_START = CNT_W'(CHIPS_PER_FRAME - CHIPS_PER_BIT);

    p_wrap_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (chip_tick_i && chip_cnt_o == LAST_CNT) |=> (chip_cnt_o == '0));

    p_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (chip_tick_i && chip_cnt_o != LAST_CNT) |=> (chip_cnt_o == $past(chip_cnt_o) + CNT_W'(1)));

    p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !chip_tick_i |=> ($stable(chip_cnt_o) && $stable(frame_stb_o) && $stable(slot_win_o)));

    p_nest_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_stb_o |-> (byte_stb_o && bit_stb_o && !slot_win_o));

    p_byte_in_bit_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_stb_o |-> bit_stb_o);

    p_pre_frame_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        pre_frame_stb_o |-> (slot_win_o && pre_byte_stb_o && chip_cnt_o == WIN_START));

    p_win_fall_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(slot_win_o) |-> frame_stb_o);

    p_win_rise_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(slot_win_o) |-> pre_frame_stb_o);

    p_pre_byte_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (pre_byte_stb_o && chip_tick_i) |=> !byte_stb_o);

    p_pin_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        share_pin_o == (pin_sel_i ? tx_data_i : slot_win_o));

    p_reset_r10: assert property (@(posedge clk_i)
        rst_i |=> (chip_cnt_o == '0 && frame_stb_o && !slot_win_o && !pre_frame_stb_o));

endmodule

bind subframe_timing_gen sft_checker #(
    .CHIPS_PER_FRAME (CHIPS_PER_FRAME),
    .CHIPS_PER_BIT   (CHIPS_PER_BIT),
    .BITS_PER_BYTE   (BITS_PER_BYTE),
    .CNT_W           (CNT_W)
) chk_i (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .chip_tick_i     (chip_tick_i),
    .pin_sel_i       (pin_sel_i),
    .tx_data_i       (tx_data_i),
    .chip_cnt_o      (chip_cnt_o),
    .bit_stb_o       (bit_stb_o),
    .byte_stb_o      (byte_stb_o),
    .frame_stb_o     (frame_stb_o),
    .pre_byte_stb_o  (pre_byte_stb_o),
    .pre_frame_stb_o (pre_frame_stb_o),
    .slot_win_o      (slot_win_o),
    .share_pin_o     (share_pin_o)
);

// File: tb/subframe_timing_gen_tb_top.sv
`timescale 1ns/1ps
module subframe_timing_gen_tb_top;

    localparam int FRAME = 2880;
    localparam int CW    = 12;

    logic          clk;
    logic          rst;
    logic          tick;
    logic          sel;
    logic          txd;
    logic [CW-1:0] cnt;
    logic          bit_s, byte_s, frame_s, pre_byte_s, pre_frame_s, win_s, pin_s;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit done   = 0;

    subframe_timing_gen dut_i (
        .clk_i           (clk),
        .rst_i           (rst),
        .chip_tick_i     (tick),
        .pin_sel_i       (sel),
        .tx_data_i       (txd),
        .chip_cnt_o      (cnt),
        .bit_stb_o       (bit_s),
        .byte_stb_o      (byte_s),
        .frame_stb_o     (frame_s),
        .pre_byte_stb_o  (pre_byte_s),
        .pre_frame_stb_o (pre_frame_s),
        .slot_win_o      (win_s),
        .share_pin_o     (pin_s)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic bit exp_bit(int c);       return (c % 8) == 0;              endfunction
    function automatic bit exp_byte(int c);      return (c % 64) == 0;             endfunction
    function automatic bit exp_frame(int c);     return c == 0;                    endfunction
    function automatic bit exp_pre_byte(int c);  return ((c + 8) % 64) == 0;       endfunction
    function automatic bit exp_pre_frame(int c); return c == FRAME - 8;            endfunction
    function automatic bit exp_win(int c);       return c >= FRAME - 8;            endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (model count %0d)", req, act, exp, model);
        end
    endtask

    task automatic check_all();
        chk("R1/R2 count", int'(cnt), model);
        chk("R3 bit", int'(bit_s), int'(exp_bit(model)));
        chk("R4 byte", int'(byte_s), int'(exp_byte(model)));
        chk("R5 frame", int'(frame_s), int'(exp_frame(model)));
        chk("R6 pre_byte", int'(pre_byte_s), int'(exp_pre_byte(model)));
        chk("R7 pre_frame", int'(pre_frame_s), int'(exp_pre_frame(model)));
        chk("R8 window", int'(win_s), int'(exp_win(model)));
        chk("R9 pin", int'(pin_s), int'(sel ? txd : exp_win(model)));
    endtask

    // Drive at the falling edge, then advance the model at the rising edge
    task automatic step(bit r, bit t);
        rst  = r;
        tick = t;
        sel  = 1'($urandom_range(0, 1));
        txd  = 1'($urandom_range(0, 1));
        #0;
        chk("R9 pin live", int'(pin_s), int'(sel ? txd : exp_win(model)));
        @(posedge clk);
        if (r)      model = 0;
        else if (t) model = (model == FRAME - 1) ? 0 : model + 1;
        @(negedge clk);
        check_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; tick = 1'b0; sel = 1'b0; txd = 1'b0;
        @(negedge clk);
        // R10: reset state
        step(1'b1, 1'b0);
        chk("R10 reset frame", int'(frame_s), 1);
        chk("R10 reset window", int'(win_s), 0);
        // R2: no tick for a stretch
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
        // R1, R3-R9: dense ticks across a full wrap
        for (int i = 0; i < 3000; i++) step(1'b0, 1'b1);
        // random density
        for (int i = 0; i < 6000; i++) step(1'b0, 1'($urandom_range(0, 3) != 0));
        // R10: reset in mid-frame
        for (int i = 0; i < 100; i++) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk("R10 mid reset count", int'(cnt), 0);
        // R6/R7/R8 corner at the wrap: run to 2870, then step slowly through the wrap
        while (model != FRAME - 10) step(1'b0, 1'b1);
        for (int i = 0; i < 40; i++) step(1'b0, 1'(i % 3 == 0));
        // sparse ticks
        for (int i = 0; i < 4000; i++) step(1'b0, 1'($urandom_range(0, 7) == 0));
        finish_run();
    end

endmodule